// File: doc/BRIEF.md
# PID-Tagged Translation Cache

This block is a small fully associative store of recently used address translations. It sits beside a page-table walker. Every entry carries the virtual page number, the identifier of the process that owns it, the physical frame number, a set of attribute bits and a modified bit. A lookup compares the requested page number and the contents of a current-process register against every entry at once. It returns either a hit, with the frame, attributes and modified bit, or a miss. A miss is reported on a separate output so that an outside refill agent can walk the tables.

The refill agent writes a whole entry in one cycle. A round-robin pointer picks the slot to overwrite. If the overwritten entry was valid and modified, the block sends only its page number and process identifier back on a writeback output, so that the page table can mark that page modified. A write lookup that hits an entry whose modified bit is clear sets that bit. Two one-cycle invalidation commands are provided: one clears every entry, the other clears only the entries owned by a given process. Entries from several processes can be present together, so a context switch only reloads the current-process register.

Top module: `xlat_cache`

## Requirements
- R1: A lookup accepted in cycle t raises `rsp_valid` in cycle t+1. `rsp_hit` is 1 only when a valid entry matches both the full page number and the current process identifier. On a hit, `rsp_pfn`, `rsp_attr` and `rsp_dirty` carry that entry's fields.
- R2: An entry whose process field differs from the current process identifier never hits. The miss is shown as `miss_valid` = 1 in cycle t+1, with `miss_vpn` and `miss_pid` equal to the requested page number and the current identifier.
- R3: A page number that differs from a stored one in any single bit, the top bit included, misses. Matching on part of the page number is never enough.
- R4: When `ins_valid` and `lk_valid` are high in the same cycle, the insert proceeds. `lk_ready` is 0 in that cycle, and the stalled lookup produces no response in the next cycle.
- R5: An insert stores the page number, process, frame, attributes and modified bit exactly as given, and a later lookup returns them unchanged.
- R6: After reset the replacement pointer selects slot 0. Each insert moves it one slot onward, wrapping after the last slot. With ENTRIES slots, the insert numbered ENTRIES+1 displaces the first entry inserted.
- R7: An insert that displaces a valid entry whose modified bit is 1 raises `wb_valid` for one cycle in the next cycle, with `wb_vpn` and `wb_pid` of the displaced entry. Displacing an empty slot or an unmodified entry gives no writeback.
- R8: A write lookup (`lk_write` = 1) that hits an entry whose modified bit is 0 reports `rsp_dirty` = 0 and then sets the bit. Any later hit on that entry reports 1, including a lookup in the very next cycle.
- R9: If an insert arrives in the cycle when the pointer's slot is having its modified bit set by the previous write hit, that slot is skipped and the following slot is displaced instead.
- R10: `inv_all` clears every entry in one cycle. An insert in the same cycle still takes effect.
- R11: `inv_pid_en` with `inv_pid` clears, in one cycle, only the entries whose process field equals `inv_pid`. Entries of other processes keep hitting.
- R12: Reset leaves every entry empty, the current process identifier at 0 and all response and writeback outputs low. `pid_ld` loads `pid_in` into the current process register, and lookups use the new value from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pid_ld | input | 1 | Load the current process register |
| pid_in | input | PID_W | New current process identifier |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_write | input | 1 | Lookup is for a store access |
| lk_ready | output | 1 | Lookup accepted this cycle (low while an insert is presented) |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_pfn | output | PFN_W | Frame number of the hit entry |
| rsp_attr | output | ATTR_W | Attribute bits of the hit entry |
| rsp_dirty | output | 1 | Modified bit of the hit entry before this access |
| miss_valid | output | 1 | Miss signalled to the refill agent |
| miss_vpn | output | VPN_W | Page number that missed |
| miss_pid | output | PID_W | Process identifier of the missing lookup |
| ins_valid | input | 1 | Insert a complete entry |
| ins_vpn | input | VPN_W | Page number of the new entry |
| ins_pid | input | PID_W | Owning process of the new entry |
| ins_pfn | input | PFN_W | Frame number of the new entry |
| ins_attr | input | ATTR_W | Attribute bits of the new entry |
| ins_dirty | input | 1 | Modified bit of the new entry |
| wb_valid | output | 1 | Displaced modified entry: mark its page modified |
| wb_vpn | output | VPN_W | Page number of the displaced entry |
| wb_pid | output | PID_W | Process identifier of the displaced entry |
| inv_all | input | 1 | Clear all entries |
| inv_pid_en | input | 1 | Clear the entries of one process |
| inv_pid | input | PID_W | Process whose entries are cleared |

## Verification
The bench builds the cache with ENTRIES = 8, a 20-bit page number, an 8-bit process identifier, a 16-bit frame and 3 attribute bits. With eight slots the replacement pointer wraps after a few inserts. That brings within reach the displacement of modified and unmodified entries, the skip of a slot whose modified bit is being set, and a combined invalidate-and-insert on an almost full array. The 20-bit page number lets a stored entry and a request differ only in the top bit, which exercises full-width matching.

// File: rtl/xc_pkg.sv
// Shared helpers for the translation cache.
// Assumes: slot indices are non-negative and counts are at least 2.
package xc_pkg;

    // Next slot index with wrap-around at n.
    function automatic int wrap_inc(input int idx, input int n);
        if (idx + 1 >= n) return 0;
        return idx + 1;
    endfunction

endpackage

// File: rtl/xc_entry_array.sv
// Entry storage for the translation cache plus the parallel tag comparators.
// Each slot holds valid, page number, process id, frame, attributes and a
// modified bit. Write (insert) has priority over invalidation in the same
// cycle. The modified-bit set port is assumed never to address the slot
// being written (the victim selector guarantees this).
module xc_entry_array #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6,
    parameter int VPN_W   = 20,
    parameter int PID_W   = 8,
    parameter int PFN_W   = 16,
    parameter int ATTR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   cmp_vpn,
    input  logic [PID_W-1:0]   cmp_pid,
    output logic [ENTRIES-1:0] match_vec,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PID_W-1:0]   wr_pid,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  logic [ATTR_W-1:0]  wr_attr,
    input  logic               wr_dirty,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic               kill_all,
    input  logic               kill_pid_en,
    input  logic [PID_W-1:0]   kill_pid,
    input  logic [IDX_W-1:0]   rd_a_idx,
    output logic [PFN_W-1:0]   rd_a_pfn,
    output logic [ATTR_W-1:0]  rd_a_attr,
    output logic               rd_a_dirty,
    input  logic [IDX_W-1:0]   rd_b_idx,
    output logic               rd_b_valid,
    output logic [VPN_W-1:0]   rd_b_vpn,
    output logic [PID_W-1:0]   rd_b_pid,
    output logic               rd_b_dirty
);

    logic              valid_w [ENTRIES];
    logic              dirty_w [ENTRIES];
    logic [VPN_W-1:0]  vpn_w   [ENTRIES];
    logic [PID_W-1:0]  pid_w   [ENTRIES];
    logic [PFN_W-1:0]  pfn_w   [ENTRIES];
    logic [ATTR_W-1:0] attr_w  [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic              valid_q;
        logic              dirty_q;
        logic [VPN_W-1:0]  vpn_q;
        logic [PID_W-1:0]  pid_q;
        logic [PFN_W-1:0]  pfn_q;
        logic [ATTR_W-1:0] attr_q;
        logic              hit_wr;
        logic              kill;

        assign hit_wr = wr_en && (wr_idx == IDX_W'(i));
        assign kill   = kill_all || (kill_pid_en && (pid_q == kill_pid));

        // Valid and modified state: insert, then invalidate, then modified-bit set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                dirty_q <= 1'b0;
            end else if (hit_wr) begin
                valid_q <= 1'b1;
                dirty_q <= wr_dirty;
            end else begin
                if (kill) valid_q <= 1'b0;
                if (set_en && (set_idx == IDX_W'(i))) dirty_q <= 1'b1;
            end
        end

        // Payload fields: loaded whole on insert.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vpn_q  <= '0;
                pid_q  <= '0;
                pfn_q  <= '0;
                attr_q <= '0;
            end else if (hit_wr) begin
                vpn_q  <= wr_vpn;
                pid_q  <= wr_pid;
                pfn_q  <= wr_pfn;
                attr_q <= wr_attr;
            end
        end

        assign match_vec[i] = valid_q && (vpn_q == cmp_vpn) && (pid_q == cmp_pid);
        assign valid_w[i]   = valid_q;
        assign dirty_w[i]   = dirty_q;
        assign vpn_w[i]     = vpn_q;
        assign pid_w[i]     = pid_q;
        assign pfn_w[i]     = pfn_q;
        assign attr_w[i]    = attr_q;
    end

    assign rd_a_pfn   = pfn_w[rd_a_idx];
    assign rd_a_attr  = attr_w[rd_a_idx];
    assign rd_a_dirty = dirty_w[rd_a_idx];
    assign rd_b_valid = valid_w[rd_b_idx];
    assign rd_b_vpn   = vpn_w[rd_b_idx];
    assign rd_b_pid   = pid_w[rd_b_idx];
    assign rd_b_dirty = dirty_w[rd_b_idx];

endmodule

// File: rtl/xc_match_enc.sv
// Turns the comparator vector into a hit flag and a slot index.
// Assumes at most one bit is set (the refill agent never inserts a
// page/process pair that is already present), so an OR-encode suffices.
module xc_match_enc #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input  logic [ENTRIES-1:0] match_vec,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    // OR together the index of every matching slot.
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) idx = idx | IDX_W'(i);
        end
    end

    assign any = |match_vec;

endmodule

// File: rtl/xc_victim_sel.sv
// Round-robin replacement pointer. The slot under the pointer is skipped
// when its modified bit is being set in this cycle; after an insert the
// pointer moves one past the slot actually used.
// Assumes: only one pending modified-bit set at a time.
module xc_victim_sel #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             busy_en,
    input  logic [IDX_W-1:0] busy_idx,
    output logic [IDX_W-1:0] victim_idx
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] ptr_nxt;

    assign ptr_nxt = IDX_W'(xc_pkg::wrap_inc(int'(ptr_q), ENTRIES));

    // Pick the pointer slot unless it is being written this cycle.
    always_comb begin
        victim_idx = (busy_en && (ptr_q == busy_idx)) ? ptr_nxt : ptr_q;
    end

    // Advance past the slot used by each insert.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else if (adv) ptr_q <= IDX_W'(xc_pkg::wrap_inc(int'(victim_idx), ENTRIES));
    end

endmodule

// File: rtl/xlat_cache.sv
// PID-tagged fully associative translation cache.
// Lookups are registered: a request accepted in cycle t answers in t+1.
// Misses go out to a refill agent, which inserts whole entries. A displaced
// modified entry reports only its page/process so the table can mark it
// modified. A write hit sets the modified bit one cycle after the lookup,
// and that pending set is forwarded to later lookups.
// Assumes: no duplicate page/process pair is ever inserted.
module xlat_cache #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PID_W   = 8,
    parameter int PFN_W   = 16,
    parameter int ATTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pid_ld,
    input  logic [PID_W-1:0]  pid_in,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              lk_write,
    output logic              lk_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [ATTR_W-1:0] rsp_attr,
    output logic              rsp_dirty,
    output logic              miss_valid,
    output logic [VPN_W-1:0]  miss_vpn,
    output logic [PID_W-1:0]  miss_pid,
    input  logic              ins_valid,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [PID_W-1:0]  ins_pid,
    input  logic [PFN_W-1:0]  ins_pfn,
    input  logic [ATTR_W-1:0] ins_attr,
    input  logic              ins_dirty,
    output logic              wb_valid,
    output logic [VPN_W-1:0]  wb_vpn,
    output logic [PID_W-1:0]  wb_pid,
    input  logic              inv_all,
    input  logic              inv_pid_en,
    input  logic [PID_W-1:0]  inv_pid
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [PID_W-1:0]   cur_pid_q;
    logic               accept;
    logic [ENTRIES-1:0] match_vec;
    logic               hit_any;
    logic [IDX_W-1:0]   hit_idx;
    logic [PFN_W-1:0]   hit_pfn;
    logic [ATTR_W-1:0]  hit_attr;
    logic               hit_dirty_raw;
    logic               hit_dirty;
    logic [IDX_W-1:0]   victim_idx;
    logic               vb_valid;
    logic [VPN_W-1:0]   vb_vpn;
    logic [PID_W-1:0]   vb_pid;
    logic               vb_dirty;
    logic               pend_set;
    logic [IDX_W-1:0]   pend_idx;

    logic               r_valid_q;
    logic               r_hit_q;
    logic               r_write_q;
    logic [IDX_W-1:0]   r_idx_q;
    logic [PFN_W-1:0]   r_pfn_q;
    logic [ATTR_W-1:0]  r_attr_q;
    logic               r_dirty_q;
    logic [VPN_W-1:0]   r_vpn_q;
    logic [PID_W-1:0]   r_pid_q;
    logic               wb_valid_q;
    logic [VPN_W-1:0]   wb_vpn_q;
    logic [PID_W-1:0]   wb_pid_q;

    // Current process register.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_pid_q <= '0;
        else if (pid_ld) cur_pid_q <= pid_in;
    end

    assign lk_ready = !ins_valid;
    assign accept   = lk_valid && !ins_valid;

    assign pend_set = r_valid_q && r_hit_q && r_write_q && !r_dirty_q;
    assign pend_idx = r_idx_q;

    xc_entry_array #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W),
        .PID_W(PID_W), .PFN_W(PFN_W), .ATTR_W(ATTR_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_vpn    (lk_vpn),
        .cmp_pid    (cur_pid_q),
        .match_vec  (match_vec),
        .wr_en      (ins_valid),
        .wr_idx     (victim_idx),
        .wr_vpn     (ins_vpn),
        .wr_pid     (ins_pid),
        .wr_pfn     (ins_pfn),
        .wr_attr    (ins_attr),
        .wr_dirty   (ins_dirty),
        .set_en     (pend_set),
        .set_idx    (pend_idx),
        .kill_all   (inv_all),
        .kill_pid_en(inv_pid_en),
        .kill_pid   (inv_pid),
        .rd_a_idx   (hit_idx),
        .rd_a_pfn   (hit_pfn),
        .rd_a_attr  (hit_attr),
        .rd_a_dirty (hit_dirty_raw),
        .rd_b_idx   (victim_idx),
        .rd_b_valid (vb_valid),
        .rd_b_vpn   (vb_vpn),
        .rd_b_pid   (vb_pid),
        .rd_b_dirty (vb_dirty)
    );

    xc_match_enc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_enc (
        .match_vec(match_vec),
        .any      (hit_any),
        .idx      (hit_idx)
    );

    xc_victim_sel #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (ins_valid),
        .busy_en   (pend_set),
        .busy_idx  (pend_idx),
        .victim_idx(victim_idx)
    );

    // Forward a modified-bit set that has not reached storage yet.
    assign hit_dirty = hit_dirty_raw || (pend_set && (pend_idx == hit_idx));

    // Lookup response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_valid_q <= 1'b0;
            r_hit_q   <= 1'b0;
            r_write_q <= 1'b0;
            r_idx_q   <= '0;
            r_pfn_q   <= '0;
            r_attr_q  <= '0;
            r_dirty_q <= 1'b0;
            r_vpn_q   <= '0;
            r_pid_q   <= '0;
        end else begin
            r_valid_q <= accept;
            r_hit_q   <= accept && hit_any;
            r_write_q <= lk_write;
            r_idx_q   <= hit_idx;
            r_pfn_q   <= hit_pfn;
            r_attr_q  <= hit_attr;
            r_dirty_q <= hit_dirty;
            r_vpn_q   <= lk_vpn;
            r_pid_q   <= cur_pid_q;
        end
    end

    // Writeback of the modified bit of a displaced entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid_q <= 1'b0;
            wb_vpn_q   <= '0;
            wb_pid_q   <= '0;
        end else begin
            wb_valid_q <= ins_valid && vb_valid && vb_dirty;
            wb_vpn_q   <= vb_vpn;
            wb_pid_q   <= vb_pid;
        end
    end

    assign rsp_valid  = r_valid_q;
    assign rsp_hit    = r_valid_q && r_hit_q;
    assign rsp_pfn    = r_pfn_q;
    assign rsp_attr   = r_attr_q;
    assign rsp_dirty  = r_dirty_q;
    assign miss_valid = r_valid_q && !r_hit_q;
    assign miss_vpn   = r_vpn_q;
    assign miss_pid   = r_pid_q;
    assign wb_valid   = wb_valid_q;
    assign wb_vpn     = wb_vpn_q;
    assign wb_pid     = wb_pid_q;

endmodule

// File: rtl/xc_chk.sv
// Property checker for xlat_cache, attached by bind.
// Assumes the bench holds inputs low during reset.
module xc_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             ins_valid,
    input logic             inv_all,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             wb_valid,
    input logic             pend_set,
    input logic [IDX_W-1:0] pend_idx,
    input logic [IDX_W-1:0] victim_idx
);

    // R1
    resp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid && !ins_valid));

    // R4
    stall_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lk_valid && ins_valid) |-> !rsp_valid);

    // R7
    wb_needs_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(ins_valid));

    // R9
    skip_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && pend_set) |-> (victim_idx != pend_idx));

    // R10
    flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inv_all, 2) && !$past(ins_valid, 2) && $past(lk_valid && !ins_valid))
        |-> !rsp_hit);

endmodule

bind xlat_cache xc_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .ins_valid (ins_valid),
    .inv_all   (inv_all),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .wb_valid  (wb_valid),
    .pend_set  (pend_set),
    .pend_idx  (pend_idx),
    .victim_idx(victim_idx)
);

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;

    localparam int ENTRIES = 8;
    localparam int VPN_W   = 20;
    localparam int PID_W   = 8;
    localparam int PFN_W   = 16;
    localparam int ATTR_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pid_ld = 1'b0;
    logic [PID_W-1:0]  pid_in = '0;
    logic              lk_valid = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic              lk_write = 1'b0;
    logic              lk_ready;
    logic              rsp_valid, rsp_hit, rsp_dirty, miss_valid, wb_valid;
    logic [PFN_W-1:0]  rsp_pfn;
    logic [ATTR_W-1:0] rsp_attr;
    logic [VPN_W-1:0]  miss_vpn, wb_vpn;
    logic [PID_W-1:0]  miss_pid, wb_pid;
    logic              ins_valid = 1'b0;
    logic [VPN_W-1:0]  ins_vpn = '0;
    logic [PID_W-1:0]  ins_pid = '0;
    logic [PFN_W-1:0]  ins_pfn = '0;
    logic [ATTR_W-1:0] ins_attr = '0;
    logic              ins_dirty = 1'b0;
    logic              inv_all = 1'b0;
    logic              inv_pid_en = 1'b0;
    logic [PID_W-1:0]  inv_pid = '0;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    xlat_cache #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W),
                 .PFN_W(PFN_W), .ATTR_W(ATTR_W)) dut (.*);

    typedef struct packed {
        logic [3:0]        req;
        logic [VPN_W-1:0]  vpn;
        logic              wr;
        logic              hit;
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              dirty;
    } vec_t;

    // Lookups with current process 5 after the first four inserts.
    localparam vec_t VECS [8] = '{
        '{4'd1, 20'h00010, 1'b0, 1'b1, 16'h0100, 3'd1, 1'b0}, // R1
        '{4'd5, 20'h00011, 1'b0, 1'b1, 16'h0101, 3'd2, 1'b1}, // R5
        '{4'd3, 20'h80010, 1'b0, 1'b1, 16'h0300, 3'd0, 1'b0}, // R3
        '{4'd3, 20'h80011, 1'b0, 1'b0, 16'h0000, 3'd0, 1'b0}, // R3 top bit only
        '{4'd3, 20'h00012, 1'b0, 1'b0, 16'h0000, 3'd0, 1'b0}, // R3
        '{4'd8, 20'h00010, 1'b1, 1'b1, 16'h0100, 3'd1, 1'b0}, // R8 pre-value
        '{4'd8, 20'h00010, 1'b0, 1'b1, 16'h0100, 3'd1, 1'b1}, // R8 next cycle
        '{4'd8, 20'h00011, 1'b1, 1'b1, 16'h0101, 3'd2, 1'b1}  // R8 already set
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic lookup(input logic [VPN_W-1:0] v, input logic wr);
        lk_valid = 1'b1; lk_vpn = v; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
    endtask

    task automatic insert(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                          input logic [PFN_W-1:0] f, input logic [ATTR_W-1:0] a,
                          input logic d);
        ins_valid = 1'b1; ins_vpn = v; ins_pid = p; ins_pfn = f; ins_attr = a; ins_dirty = d;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic set_pid(input logic [PID_W-1:0] p);
        pid_ld = 1'b1; pid_in = p;
        @(negedge clk);
        pid_ld = 1'b0;
    endtask

    task automatic expect_hit(input string tag, input logic [VPN_W-1:0] v,
                              input logic [PFN_W-1:0] f, input logic d);
        lookup(v, 1'b0);
        check({tag, " hit"}, 32'(rsp_hit), 32'd1);
        check({tag, " pfn"}, 32'(rsp_pfn), 32'(f));
        check({tag, " dirty"}, 32'(rsp_dirty), 32'(d));
    endtask

    task automatic expect_miss(input string tag, input logic [VPN_W-1:0] v);
        lookup(v, 1'b0);
        check({tag, " miss"}, 32'(miss_valid), 32'd1);
        check({tag, " hit"}, 32'(rsp_hit), 32'd0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check("R12 lk_ready", 32'(lk_ready), 32'd1);
        check("R12 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R12 wb_valid", 32'(wb_valid), 32'd0);
        lookup(20'h00010, 1'b0);
        check("R12 empty miss", 32'(miss_valid), 32'd1);
        check("R12 pid reset", 32'(miss_pid), 32'd0);

        // R12 load current process, then fill slots 0..3
        set_pid(8'd5);
        insert(20'h00010, 8'd5, 16'h0100, 3'd1, 1'b0);
        insert(20'h00011, 8'd5, 16'h0101, 3'd2, 1'b1);
        insert(20'h00010, 8'd7, 16'h0200, 3'd3, 1'b0);
        insert(20'h80010, 8'd5, 16'h0300, 3'd0, 1'b0);

        // Table walk: R1 R3 R5 R8
        for (int i = 0; i < 8; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            lookup(VECS[i].vpn, VECS[i].wr);
            check({tag, " valid"}, 32'(rsp_valid), 32'd1);
            check({tag, " hit"}, 32'(rsp_hit), 32'(VECS[i].hit));
            if (VECS[i].hit) begin
                check({tag, " pfn"}, 32'(rsp_pfn), 32'(VECS[i].pfn));
                check({tag, " attr"}, 32'(rsp_attr), 32'(VECS[i].attr));
                check({tag, " dirty"}, 32'(rsp_dirty), 32'(VECS[i].dirty));
            end else begin
                check({tag, " miss_vpn"}, 32'(miss_vpn), 32'(VECS[i].vpn));
                check({tag, " miss_pid"}, 32'(miss_pid), 32'd5);
            end
        end

        // R4: insert and lookup together; lookup stalls
        lk_valid = 1'b1; lk_vpn = 20'h00010;
        ins_valid = 1'b1; ins_vpn = 20'h00020; ins_pid = 8'd5;
        ins_pfn = 16'h0400; ins_attr = 3'd0; ins_dirty = 1'b1;
        #1;
        check("R4 lk_ready low", 32'(lk_ready), 32'd0);
        @(negedge clk);
        lk_valid = 1'b0; ins_valid = 1'b0;
        check("R4 no response", 32'(rsp_valid), 32'd0);
        expect_hit("R4 insert done", 20'h00020, 16'h0400, 1'b1);

        // R2: process switch
        set_pid(8'd7);
        expect_hit("R2 pid7", 20'h00010, 16'h0200, 1'b0);
        expect_miss("R2 other pid", 20'h00011);
        check("R2 miss_pid", 32'(miss_pid), 32'd7);
        check("R2 miss_vpn", 32'(miss_vpn), 32'h00011);

        // R11: clear process 7 only
        inv_pid_en = 1'b1; inv_pid = 8'd7;
        @(negedge clk);
        inv_pid_en = 1'b0;
        expect_miss("R11 cleared", 20'h00010);
        set_pid(8'd5);
        expect_hit("R11 kept", 20'h00010, 16'h0100, 1'b1);

        // R6 R7: fill slots 5..7 (empty, no writeback)
        insert(20'h00030, 8'd5, 16'h0030, 3'd0, 1'b0);
        check("R7 empty no wb", 32'(wb_valid), 32'd0);
        insert(20'h00031, 8'd5, 16'h0031, 3'd0, 1'b0);
        insert(20'h00032, 8'd5, 16'h0032, 3'd0, 1'b0);
        // pointer wrapped: slot 0 holds modified 0x00010
        insert(20'h00040, 8'd5, 16'h0040, 3'd0, 1'b0);
        check("R7 wb dirty", 32'(wb_valid), 32'd1);
        check("R6 wb_vpn first", 32'(wb_vpn), 32'h00010);
        check("R7 wb_pid", 32'(wb_pid), 32'd5);
        expect_miss("R6 displaced", 20'h00010);
        insert(20'h00041, 8'd5, 16'h0041, 3'd0, 1'b0);
        check("R7 wb second", 32'(wb_valid), 32'd1);
        check("R6 wb_vpn second", 32'(wb_vpn), 32'h00011);
        insert(20'h00042, 8'd5, 16'h0042, 3'd0, 1'b0);
        check("R7 cleared slot no wb", 32'(wb_valid), 32'd0);

        // R9: write hit on slot 3, insert next cycle skips to slot 4
        lookup(20'h80010, 1'b1);
        check("R9 write hit", 32'(rsp_hit), 32'd1);
        check("R9 pre dirty", 32'(rsp_dirty), 32'd0);
        insert(20'h00043, 8'd5, 16'h0430, 3'd0, 1'b0);
        check("R9 wb from slot4", 32'(wb_valid), 32'd1);
        check("R9 wb_vpn", 32'(wb_vpn), 32'h00020);
        expect_hit("R9 skipped kept", 20'h80010, 16'h0300, 1'b1);
        expect_miss("R9 slot4 gone", 20'h00020);
        expect_hit("R9 new entry", 20'h00043, 16'h0430, 1'b0);

        // R7: unmodified displacement gives no writeback
        insert(20'h00044, 8'd5, 16'h0440, 3'd0, 1'b0);
        check("R7 clean no wb", 32'(wb_valid), 32'd0);
        expect_miss("R6 slot5 gone", 20'h00030);
        expect_hit("R6 slot7 kept", 20'h00032, 16'h0032, 1'b0);

        // R10: flush all with an insert in the same cycle
        inv_all = 1'b1;
        ins_valid = 1'b1; ins_vpn = 20'h00050; ins_pid = 8'd5;
        ins_pfn = 16'h0500; ins_attr = 3'd4; ins_dirty = 1'b0;
        @(negedge clk);
        inv_all = 1'b0; ins_valid = 1'b0;
        check("R10 clean victim no wb", 32'(wb_valid), 32'd0);
        expect_miss("R10 flushed", 20'h80010);
        expect_miss("R10 flushed b", 20'h00044);
        expect_hit("R10 insert survives", 20'h00050, 16'h0500, 1'b0);
        check("R10 attr", 32'(rsp_attr), 32'd4);

        finish_run();
    end

endmodule